// File: doc/BRIEF.md
# Dual-Action Timer Channel

This block is one timer I/O channel with its own pair of free-running 24-bit timebases. Each timebase has a prescaler, and each of the two action units can watch either timebase. An action unit works in one of two modes. As a compare it waits for its timebase to reach a programmed value and then drives the output pin high or low, or toggles it. As a capture it latches the current timebase value when a chosen edge arrives on the input pin. Every event raises a sticky service request. The servicing side then computes the next event time, for example the previous edge time plus a high or low duration for PWM, and re-arms the units.

Two armed units can produce a pulse as narrow as one timebase tick with no help from the servicing side. A unit fires once and then disarms. Any further edge waits until the servicing side writes the control register again. The servicing side reaches the channel through a plain register port with an 8-entry map and a combinational read. It can also force a pin action at once.

Top module: `tmr_dual_channel`

## Requirements
- R1: After reset the pin output is 0, the service request is 0, both timebases read 0, both prescalers read 0, all status bits read 0 and both units read back as disarmed with control value 0.
- R2: A timebase with prescaler setting p advances by exactly one every 2*(p+1) clocks. The prescaler register at address 5 holds timebase 0 in bits [3:0] and timebase 1 in bits [7:4]. Addresses 6 and 7 read timebase 0 and timebase 1.
- R3: The unit control registers are at address 2 (unit 0) and address 3 (unit 1). Bit 0 is arm, bit 1 selects capture (1) or compare (0), bit 2 selects the timebase, and bits [4:3] hold a code. Address 0 and address 1 hold the value registers. An armed compare unit acts on the clock edge after its selected timebase first equals its value. Its code gives the action: 0 none, 1 drive high, 2 drive low, 3 toggle.
- R4: With bit 2 set, a unit compares against or captures from timebase 1. With bit 2 clear it uses timebase 0.
- R5: Two compare units armed for consecutive ticks of a prescaler-0 timebase, one driving high and one driving low, give a high pulse exactly 2 clocks wide.
- R6: In capture mode, code bit 0 enables rising edges and code bit 1 enables falling edges. The input passes through a two-flop synchronizer. The unit latches the selected timebase value as it stands on the second clock edge after the first edge that samples the new input level.
- R7: A unit clears its own arm bit when it fires. It then ignores further matches and input edges, and its value and status bit stay unchanged, until a control write sets arm again.
- R8: The status register is at address 4: bit 0 is event 0, bit 1 is event 1, bit 2 is the service request, bit 3 is overrun and bit 4 is the pin level (read-only). Writing 1 to any of bits 0 to 3 clears that bit. The service request stays set until it is cleared. An event that arrives while the request is set and not being cleared in the same cycle sets overrun. When an event coincides with a clear, the event wins.
- R9: A write to address 6 applies the action code in bits [1:0] to the pin on that write's clock edge.
- R10: Actions that land on the same clock edge are applied in a fixed order: unit 0 first, then unit 1, then a forced action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 3 | Register address for write and read |
| reg_wdata | input | 24 | Write data |
| reg_rdata | output | 24 | Read data for reg_addr (combinational) |
| pin_in | input | 1 | Asynchronous channel input pin |
| pin_out | output | 1 | Channel output pin |
| srq_out | output | 1 | Service request level |

## Verification
The bench runs a cycle-by-cycle reference model and compares the pin, the service request and the read data on every clock. Around that comparison it targets the corners that are easy to get wrong:
- Match timing is pinned to the exact timebase value. A design that fired one tick late, or fired again while the timebase held its value, would be caught.
- The two-clock pulse is measured. An extra pipeline stage on the pin would widen it.
- The capture latency through the synchronizer is checked.
- The bench sends extra input edges after both units have fired. A design that failed to disarm would overwrite its capture or set an event bit.
- Overrun on back-to-back events is checked, and so is a collision between a compare and a toggle on the same edge. A design with the wrong application order would leave the pin high.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [2:0] {
    A_VAL0 = 3'd0,
    A_VAL1 = 3'd1,
    A_CTL0 = 3'd2,
    A_CTL1 = 3'd3,
    A_STAT = 3'd4,
    A_PRE  = 3'd5,
    A_TB0  = 3'd6,
    A_TB1  = 3'd7
  } reg_addr_e;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_HIGH   = 2'd1,
    ACT_LOW    = 2'd2,
    ACT_TOGGLE = 2'd3
  } pin_act_e;

  // Field order matches the control register layout, arm in bit 0.
  typedef struct packed {
    logic [1:0] code;
    logic       sel;
    logic       capture;
    logic       arm;
  } unit_ctl_t;

  function automatic logic apply_act(input logic cur, input pin_act_e a);
    case (a)
      ACT_HIGH:   return 1'b1;
      ACT_LOW:    return 1'b0;
      ACT_TOGGLE: return ~cur;
      default:    return cur;
    endcase
  endfunction

endpackage

// File: rtl/tmr_timebase.sv
module tmr_timebase #(
  parameter int CNT_W = 24,
  parameter int PRE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PRE_W-1:0] pre,
  output logic [CNT_W-1:0] count
);
  localparam int DIV_W = PRE_W + 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] div_lim;
  logic             tick;

  // Period 2*(pre+1): the divider runs 0 .. 2*pre+1.
  assign div_lim = {pre, 1'b1};
  assign tick    = (div_q >= div_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      count <= '0;
    end else if (tick) begin
      div_q <= '0;
      count <= count + 1'b1;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (count != $past(count)) |-> (count == $past(count) + 1'b1));

  p_min_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (count != $past(count)) |=> $stable(count));

endmodule

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  // STAGES synchronizer flops plus one history flop.
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], din};
  end

  assign rise =  sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall = ~sh_q[STAGES-1] &  sh_q[STAGES];

endmodule

// File: rtl/tmr_action_unit.sv
module tmr_action_unit
  import tmr_pkg::*;
#(
  parameter int TB_W = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0][TB_W-1:0] tbs,
  input  logic                 ctl_we,
  input  unit_ctl_t            ctl_wd,
  input  logic                 val_we,
  input  logic [TB_W-1:0]      val_wd,
  input  logic                 edge_rise,
  input  logic                 edge_fall,
  output logic                 fire,
  output pin_act_e             act,
  output logic [TB_W-1:0]      value,
  output unit_ctl_t            ctl_rd
);
  unit_ctl_t       ctl_q;
  logic [TB_W-1:0] val_q;
  logic [TB_W-1:0] tb_now;
  logic            hit_cmp;
  logic            hit_cap;

  assign tb_now  = tbs[ctl_q.sel];
  assign hit_cmp = !ctl_q.capture && (tb_now == val_q);
  assign hit_cap =  ctl_q.capture &&
                    ((ctl_q.code[0] && edge_rise) || (ctl_q.code[1] && edge_fall));
  assign fire    = ctl_q.arm && (hit_cmp || hit_cap);
  assign act     = (fire && !ctl_q.capture) ? pin_act_e'(ctl_q.code) : ACT_NONE;
  assign value   = val_q;
  assign ctl_rd  = ctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_we) ctl_q <= ctl_wd;
    else if (fire)   ctl_q.arm <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       val_q <= '0;
    else if (val_we)                  val_q <= val_wd;
    else if (fire && ctl_q.capture)   val_q <= tb_now;
  end

  p_disarm_after_fire_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !ctl_we) |=> !ctl_rd.arm);

  p_capture_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && ctl_q.capture && !val_we) |=> (value == $past(tb_now)));

  p_value_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && !val_we) |=> $stable(value));

endmodule

// File: rtl/tmr_dual_channel.sv
module tmr_dual_channel
  import tmr_pkg::*;
#(
  parameter int TB_W        = 24,
  parameter int PRE_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [2:0]      reg_addr,
  input  logic [TB_W-1:0] reg_wdata,
  output logic [TB_W-1:0] reg_rdata,
  input  logic            pin_in,
  output logic            pin_out,
  output logic            srq_out
);
  localparam int NUNITS = 2;
  localparam int NTB    = 2;
  localparam int CTL_W  = $bits(unit_ctl_t);
  localparam int STAT_W = NUNITS + 3;

  reg_addr_e addr;
  assign addr = reg_addr_e'(reg_addr);

  // ---------------- timebases ----------------
  logic [NTB*PRE_W-1:0]    pre_q;
  logic [1:0][TB_W-1:0]    tbs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        pre_q <= '0;
    else if (reg_wr && addr == A_PRE)  pre_q <= reg_wdata[NTB*PRE_W-1:0];
  end

  for (genvar t = 0; t < NTB; t++) begin : g_tb
    tmr_timebase #(.CNT_W(TB_W), .PRE_W(PRE_W)) u_tb (
      .clk   (clk),
      .rst_n (rst_n),
      .pre   (pre_q[t*PRE_W +: PRE_W]),
      .count (tbs[t])
    );
  end

  // ---------------- input edge detect ----------------
  logic edge_rise, edge_fall;

  tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (pin_in),
    .rise  (edge_rise),
    .fall  (edge_fall)
  );

  // ---------------- action units ----------------
  logic [NUNITS-1:0] fire;
  pin_act_e          unit_act [NUNITS];
  logic [TB_W-1:0]   unit_val [NUNITS];
  unit_ctl_t         unit_ctl [NUNITS];

  for (genvar u = 0; u < NUNITS; u++) begin : g_unit
    logic ctl_we, val_we;
    assign val_we = reg_wr && (reg_addr == 3'(int'(A_VAL0) + u));
    assign ctl_we = reg_wr && (reg_addr == 3'(int'(A_CTL0) + u));

    tmr_action_unit #(.TB_W(TB_W)) u_act (
      .clk       (clk),
      .rst_n     (rst_n),
      .tbs       (tbs),
      .ctl_we    (ctl_we),
      .ctl_wd    (unit_ctl_t'(reg_wdata[CTL_W-1:0])),
      .val_we    (val_we),
      .val_wd    (reg_wdata),
      .edge_rise (edge_rise),
      .edge_fall (edge_fall),
      .fire      (fire[u]),
      .act       (unit_act[u]),
      .value     (unit_val[u]),
      .ctl_rd    (unit_ctl[u])
    );
  end

  // ---------------- pin logic ----------------
  logic pin_q, pin_d, force_we;

  assign force_we = reg_wr && (addr == A_TB0);

  always_comb begin
    pin_d = pin_q;
    for (int u = 0; u < NUNITS; u++) pin_d = apply_act(pin_d, unit_act[u]);
    if (force_we) pin_d = apply_act(pin_d, pin_act_e'(reg_wdata[1:0]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin_d;
  end

  assign pin_out = pin_q;

  // ---------------- status / service request ----------------
  logic [NUNITS-1:0] ev_q;
  logic              srq_q, ovr_q;
  logic              stat_we, any_fire, srq_keep;

  assign stat_we  = reg_wr && (addr == A_STAT);
  assign any_fire = |fire;
  assign srq_keep = srq_q && !(stat_we && reg_wdata[NUNITS]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_q  <= '0;
      srq_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      ev_q  <= (ev_q & ~(stat_we ? reg_wdata[NUNITS-1:0] : '0)) | fire;
      srq_q <= srq_keep || any_fire;
      ovr_q <= (ovr_q && !(stat_we && reg_wdata[NUNITS+1])) || (any_fire && srq_keep);
    end
  end

  assign srq_out = srq_q;

  // ---------------- read mux ----------------
  always_comb begin
    case (addr)
      A_VAL0:  reg_rdata = unit_val[0];
      A_VAL1:  reg_rdata = unit_val[1];
      A_CTL0:  reg_rdata = {{(TB_W-CTL_W){1'b0}}, unit_ctl[0]};
      A_CTL1:  reg_rdata = {{(TB_W-CTL_W){1'b0}}, unit_ctl[1]};
      A_STAT:  reg_rdata = {{(TB_W-STAT_W){1'b0}}, pin_q, ovr_q, srq_q, ev_q};
      A_PRE:   reg_rdata = {{(TB_W-NTB*PRE_W){1'b0}}, pre_q};
      A_TB0:   reg_rdata = tbs[0];
      default: reg_rdata = tbs[1];
    endcase
  end

  // ---------------- assertions ----------------
  p_srq_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (srq_out && !(stat_we && reg_wdata[NUNITS])) |=> srq_out);

  p_ovr_needs_srq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_q) |-> $past(srq_out));

  p_pin_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_fire && !force_we) |=> $stable(pin_out));

  p_force_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (force_we && reg_wdata[1:0] == 2'd1) |=> pin_out);

  p_event_sets_srq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    any_fire |=> srq_out);

endmodule

// File: tb/tb_tmr_dual_channel.sv
module tb_tmr_dual_channel;
  logic        clk = 0, rst_n = 0, wr = 0, pin_in = 0;
  logic [2:0]  addr = 0;
  logic [23:0] wdata = 0;
  logic [23:0] rdata;
  logic        pin_out, srq_out;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tmr_dual_channel dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(wr), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .srq_out(srq_out)
  );

  // ---------------- reference model ----------------
  logic [23:0] m_tb [2], m_val [2];
  int          m_div [2];
  logic [3:0]  m_pre [2];
  logic        m_arm [2], m_cap [2], m_sel [2], m_ev [2];
  logic [1:0]  m_code [2];
  logic        m_srq, m_ovr, m_pin;
  logic [2:0]  m_s;

  function automatic logic do_act(input logic c, input logic [1:0] a);
    if (a == 2'd1) return 1'b1;
    if (a == 2'd2) return 1'b0;
    if (a == 2'd3) return ~c;
    return c;
  endfunction

  function automatic logic [23:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return m_val[0];
      3'd1: return m_val[1];
      3'd2: return {19'd0, m_code[0], m_sel[0], m_cap[0], m_arm[0]};
      3'd3: return {19'd0, m_code[1], m_sel[1], m_cap[1], m_arm[1]};
      3'd4: return {19'd0, m_pin, m_ovr, m_srq, m_ev[1], m_ev[0]};
      3'd5: return {16'd0, m_pre[1], m_pre[0]};
      3'd6: return m_tb[0];
      default: return m_tb[1];
    endcase
  endfunction

  always @(posedge clk) begin
    logic f [2];
    logic rise, fall, clr, keep, anyf, p;
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        m_tb[i] = 0; m_val[i] = 0; m_div[i] = 0; m_pre[i] = 0; m_arm[i] = 0;
        m_cap[i] = 0; m_sel[i] = 0; m_ev[i] = 0; m_code[i] = 0;
      end
      m_srq = 0; m_ovr = 0; m_pin = 0; m_s = 0;
    end else begin
      rise = m_s[1] & ~m_s[2];
      fall = ~m_s[1] & m_s[2];
      for (int u = 0; u < 2; u++)
        f[u] = m_arm[u] && (m_cap[u] ? ((m_code[u][0] && rise) || (m_code[u][1] && fall))
                                     : (m_tb[m_sel[u]] == m_val[u]));
      p = m_pin;
      for (int u = 0; u < 2; u++) if (f[u] && !m_cap[u]) p = do_act(p, m_code[u]);
      if (wr && addr == 3'd6) p = do_act(p, wdata[1:0]);
      clr  = wr && addr == 3'd4;
      keep = m_srq && !(clr && wdata[2]);
      anyf = f[0] || f[1];
      m_ovr = (m_ovr && !(clr && wdata[3])) || (anyf && keep);
      m_srq = keep || anyf;
      for (int u = 0; u < 2; u++) begin
        m_ev[u] = (m_ev[u] && !(clr && wdata[u])) || f[u];
        if (wr && addr == 3'(u)) m_val[u] = wdata;
        else if (f[u] && m_cap[u]) m_val[u] = m_tb[m_sel[u]];
        if (wr && addr == 3'(2 + u)) begin
          m_arm[u] = wdata[0]; m_cap[u] = wdata[1]; m_sel[u] = wdata[2]; m_code[u] = wdata[4:3];
        end else if (f[u]) m_arm[u] = 0;
      end
      for (int t = 0; t < 2; t++) begin
        if (m_div[t] >= 2 * int'(m_pre[t]) + 1) begin m_div[t] = 0; m_tb[t] = m_tb[t] + 1; end
        else m_div[t] = m_div[t] + 1;
      end
      if (wr && addr == 3'd5) begin m_pre[0] = wdata[3:0]; m_pre[1] = wdata[7:4]; end
      m_s = {m_s[1:0], pin_in};
      m_pin = p;
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      #2;
      chk("R3 R10 pin per cycle", {31'd0, pin_out}, {31'd0, m_pin});
      chk("R8 srq per cycle", {31'd0, srq_out}, {31'd0, m_srq});
      chk("R2 R6 readback per cycle", {8'd0, rdata}, {8'd0, m_read(addr)});
    end
  end

  task automatic wr_reg(input logic [2:0] a, input logic [23:0] d);
    @(negedge clk); wr = 1; addr = a; wdata = d;
    @(negedge clk); wr = 0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [23:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [23:0] a, b, t, c0;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd_reg(3'd4, a); chk("R1 status", {8'd0, a}, 0);
    rd_reg(3'd2, a); chk("R1 ctl0", {8'd0, a}, 0);
    rd_reg(3'd5, a); chk("R1 prescaler", {8'd0, a}, 0);
    chk("R1 pin", {31'd0, pin_out}, 0);
    chk("R1 srq", {31'd0, srq_out}, 0);

    // R2 timebase rates
    rd_reg(3'd6, a); repeat (20) @(negedge clk); #1 b = rdata;
    chk("R2 tb0 p=0", {8'd0, b - a}, 10);
    wr_reg(3'd5, 24'h30);
    repeat (10) @(negedge clk);
    rd_reg(3'd7, a); repeat (40) @(negedge clk); #1 b = rdata;
    chk("R2 tb1 p=3", {8'd0, b - a}, 5);

    // R3 compare drives high at the exact value
    rd_reg(3'd6, t);
    wr_reg(3'd0, t + 8);
    wr_reg(3'd2, 24'h09);
    addr = 3'd6; n = 0;
    while (!pin_out && n < 100) begin @(negedge clk); #1; n++; end
    chk("R3 pin high", {31'd0, pin_out}, 1);
    chk("R3 fire time", {8'd0, rdata}, {8'd0, t + 8});
    rd_reg(3'd2, a); chk("R7 unit0 disarmed", {31'd0, a[0]}, 0);
    rd_reg(3'd4, a); chk("R8 ev0 and srq", {28'd0, a[3:0]}, 4'b0101);
    wr_reg(3'd4, 24'h1F);
    chk("R8 srq cleared", {31'd0, srq_out}, 0);

    // R9 force low, R5 narrow pulse
    wr_reg(3'd6, 24'h2);
    chk("R9 force low", {31'd0, pin_out}, 0);
    rd_reg(3'd6, t);
    wr_reg(3'd0, t + 10);
    wr_reg(3'd1, t + 11);
    wr_reg(3'd2, 24'h09);
    wr_reg(3'd3, 24'h11);
    n = 0;
    for (int i = 0; i < 60; i++) begin @(negedge clk); #1; if (pin_out) n++; end
    chk("R5 pulse width", n, 2);
    rd_reg(3'd4, a); chk("R8 overrun", {28'd0, a[3:0]}, 4'b1111);
    wr_reg(3'd4, 24'h1F);

    // R9 toggle
    wr_reg(3'd6, 24'h3);
    chk("R9 force toggle", {31'd0, pin_out}, 1);

    // R4 compare on timebase 1 with toggle
    rd_reg(3'd7, t);
    wr_reg(3'd1, t + 3);
    wr_reg(3'd3, 24'h1D);
    addr = 3'd7; n = 0;
    while (pin_out && n < 100) begin @(negedge clk); #1; n++; end
    chk("R4 toggled by tb1", {31'd0, pin_out}, 0);
    chk("R4 tb1 fire time", {8'd0, rdata}, {8'd0, t + 3});
    wr_reg(3'd4, 24'h1F);

    // R6 capture both edges on timebase 1
    wr_reg(3'd0, 24'h0);
    wr_reg(3'd2, 24'h0F);
    wr_reg(3'd3, 24'h17);
    @(negedge clk); pin_in = 1;
    repeat (6) @(negedge clk);
    rd_reg(3'd0, c0); chk("R6 rise capture", {8'd0, c0}, {8'd0, m_val[0]});
    @(negedge clk); pin_in = 0;
    repeat (6) @(negedge clk);
    rd_reg(3'd1, a); chk("R6 fall capture", {8'd0, a}, {8'd0, m_val[1]});
    rd_reg(3'd7, b); chk("R4 capture from tb1", {31'd0, (b - c0) <= 24'd2}, 1);
    wr_reg(3'd4, 24'h1F);

    // R7 further edges ignored until re-arm
    @(negedge clk); pin_in = 1;
    repeat (6) @(negedge clk); pin_in = 0;
    repeat (6) @(negedge clk);
    rd_reg(3'd0, a); chk("R7 value held", {8'd0, a}, {8'd0, c0});
    rd_reg(3'd4, a); chk("R7 no event", {28'd0, a[3:0]}, 0);
    wr_reg(3'd2, 24'h0F);
    @(negedge clk); pin_in = 1;
    repeat (6) @(negedge clk);
    rd_reg(3'd4, a); chk("R7 re-armed event", {31'd0, a[0]}, 1);
    wr_reg(3'd4, 24'h1F);

    // R10 same-edge ordering: high then toggle
    wr_reg(3'd6, 24'h2);
    rd_reg(3'd6, t);
    wr_reg(3'd0, t + 8);
    wr_reg(3'd1, t + 8);
    wr_reg(3'd2, 24'h09);
    wr_reg(3'd3, 24'h19);
    n = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); #1; if (pin_out) n++; end
    chk("R10 pin never high", n, 0);
    rd_reg(3'd4, a); chk("R10 both fired", {30'd0, a[1:0]}, 2'b11);

    repeat (4) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule